// File: doc/BRIEF.md
# Core Power-Up Reset Sequencer

This block takes one core of a four-core cluster from the powered-off state to running. It drives that core's reset and power-gate controls through a fixed order of steps. A start request carries a core index, a flag that says whether the core is of the big or the little type, and a variant flag that selects the alternate chip wiring. The sequencer first puts the core into reset and gets it ready. It then asks an external power-switch sequencer to open the core's supply and waits for the acknowledge. After that it removes the power gate, lets the supply settle, and releases the resets in two stages. When the last reset is released it raises a one-cycle done pulse.

All reset lines are active low. In each vector, bit k belongs to core k. The power-gate vector has one extra bit. In variant mode, core 0's gate is wired to that top bit, bit 4, instead of bit 0. In variant mode a second power-on reset line follows the first, and each change to it is followed by a short settle wait. A request for a core index outside the cluster is refused with an error pulse.

The controller is one state machine with these states:
- IDLE
- POR_SET: assert the power-on reset(s).
- POR2_HOLD: short wait, variant mode only.
- L1_CLR: drive the L1 reset-disable bit low.
- DBG_SET: assert the debug and trace resets.
- SW_WAIT: handshake with the power switch.
- GATE_CLR: clear the gate bit.
- GATE_SETTLE: long wait.
- POR_REL: release the power-on reset(s).
- POR2_SETTLE: short wait, variant mode only.
- FINISH: final release and done pulse.

The transitions are:
- IDLE to POR_SET on a valid start.
- POR_SET to POR2_HOLD in variant mode, otherwise to L1_CLR.
- POR2_HOLD to L1_CLR when the timer expires.
- L1_CLR to DBG_SET, and DBG_SET to SW_WAIT.
- SW_WAIT to GATE_CLR on the acknowledge.
- GATE_CLR to GATE_SETTLE.
- GATE_SETTLE to POR_REL when the timer expires.
- POR_REL to POR2_SETTLE in variant mode, otherwise to FINISH.
- POR2_SETTLE to FINISH when the timer expires.
- FINISH to IDLE.

Top module: `core_pwrup_seq`

## Requirements
- R1: A start in IDLE with index below 4 raises busy_o on the next edge. One edge later the power-on reset of the selected core, and only that core, goes low.
- R2: For a little core (big_core_i=0), the selected core's L1 reset-disable bit is driven to 0 before the power switch is requested. For a big core this bit is left unchanged.
- R3: The selected core's debug reset is asserted before power is applied, together with the raising of sw_req_o. The trace reset is asserted as well for a little core only.
- R4: sw_req_o stays high until sw_ack_i is sampled high. The power-gate bit is cleared exactly one cycle after sw_req_o falls, never earlier.
- R5: The cleared gate bit is bit k for core k. In variant mode, core 0 uses bit 4 and bit 0 is left unchanged.
- R6: The power-on reset is released exactly LONG_WAIT_CYC+1 cycles after the gate bit clears.
- R7: In variant mode, the second power-on reset line is asserted and released in the same cycle as the first. Each of these steps is followed by SHORT_WAIT_CYC+1 cycles before the next step appears.
- R8: The debug reset, the core reset, and either the trace reset (little core) or the SIMD reset (big core) are all released in one cycle. done_o is high for exactly that one cycle, and busy_o falls in the same cycle.
- R9: A start with index 4 or more gives a one-cycle err_o pulse on the next edge, and no other output changes.
- R10: A start while busy, or an acknowledge while no request is pending, has no effect on any output.
- R11: After reset, the outputs hold these values:
  - all power-on and second power-on resets, debug resets and trace resets are 1 (released);
  - core and SIMD resets are 0;
  - L1 reset-disable bits are 1;
  - all five gate bits are 1;
  - sw_req_o, busy_o, done_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Power-up request, sampled in IDLE |
| core_idx_i | input | 3 | Index of the core to power up |
| big_core_i | input | 1 | 1 for a big core, 0 for a little core |
| variant_i | input | 1 | Selects the alternate chip wiring |
| sw_ack_i | input | 1 | Power switch opened acknowledge |
| sw_req_o | output | 1 | Request to open the core power switch |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on the final release |
| err_o | output | 1 | One-cycle pulse for a refused index |
| por_n_o | output | 4 | Power-on resets, active low |
| por2_n_o | output | 4 | Second power-on resets (variant mode), active low |
| core_rst_n_o | output | 4 | Core resets, active low |
| dbg_rst_n_o | output | 4 | Debug resets, active low |
| trc_rst_n_o | output | 4 | Trace resets, active low |
| simd_rst_n_o | output | 4 | SIMD unit resets, active low |
| l1_rst_dis_o | output | 4 | L1 reset-disable bits |
| pwr_gate_o | output | 5 | Power-gate bits, 1 = gated off |

## Verification
Every step is a registered output of one state, so each result appears a fixed number of edges after the step before it:
- busy one edge after start, and the power-on reset one edge after that;
- the L1 bit and the debug reset one or two edges later, or SHORT_WAIT_CYC+1 or +2 in variant mode;
- the gate one edge after the switch request falls;
- the power-on release LONG_WAIT_CYC+1 edges after the gate;
- the final release one edge later, or SHORT_WAIT_CYC+1 in variant mode.

The bench records the expected output snapshot for each of these steps, together with its edge gap, in a queue. A monitor samples on the falling edge. It pops one entry for each observed change and compares both the whole snapshot and the number of rising edges since the previous change, so any early, late, missing or extra change is caught.

// File: rtl/cpwr_pkg.sv
package cpwr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POR_SET,
        ST_POR2_HOLD,
        ST_L1_CLR,
        ST_DBG_SET,
        ST_SW_WAIT,
        ST_GATE_CLR,
        ST_GATE_SETTLE,
        ST_POR_REL,
        ST_POR2_SETTLE,
        ST_FINISH
    } pwr_state_e;

endpackage

// File: rtl/cpwr_wait_timer.sv
module cpwr_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !load_i) |=> expired_o); // R6

endmodule

// File: rtl/cpwr_sel_decode.sv
module cpwr_sel_decode #(
    parameter int NCORES = 4,
    parameter int IDX_W  = 3,
    parameter int GATE_W = 5
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              variant_i,
    output logic [NCORES-1:0] core_sel_o,
    output logic [GATE_W-1:0] gate_sel_o
);

    for (genvar g = 0; g < NCORES; g++) begin : g_core
        assign core_sel_o[g] = (idx_i == IDX_W'(g));
    end

    // Core 0 moves to the top gate bit in variant mode.
    assign gate_sel_o[0]        = core_sel_o[0] & ~variant_i;
    assign gate_sel_o[GATE_W-1] = core_sel_o[0] &  variant_i;

    for (genvar g = 1; g < NCORES; g++) begin : g_gate
        assign gate_sel_o[g] = core_sel_o[g];
    end

endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
    import cpwr_pkg::*;
#(
    parameter int NCORES         = 4,
    parameter int LONG_WAIT_CYC  = 5000,
    parameter int SHORT_WAIT_CYC = 2500
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [$clog2(NCORES):0]      core_idx_i,
    input  logic                         big_core_i,
    input  logic                         variant_i,
    input  logic                         sw_ack_i,
    output logic                         sw_req_o,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         err_o,
    output logic [NCORES-1:0]            por_n_o,
    output logic [NCORES-1:0]            por2_n_o,
    output logic [NCORES-1:0]            core_rst_n_o,
    output logic [NCORES-1:0]            dbg_rst_n_o,
    output logic [NCORES-1:0]            trc_rst_n_o,
    output logic [NCORES-1:0]            simd_rst_n_o,
    output logic [NCORES-1:0]            l1_rst_dis_o,
    output logic [NCORES:0]              pwr_gate_o
);

    localparam int IDX_W   = $clog2(NCORES) + 1;
    localparam int GATE_W  = NCORES + 1;
    localparam int MAX_CYC = (LONG_WAIT_CYC > SHORT_WAIT_CYC) ? LONG_WAIT_CYC : SHORT_WAIT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    pwr_state_e state_q, state_d;

    logic [IDX_W-1:0]  idx_q;
    logic              big_q, var_q;
    logic [NCORES-1:0] core_sel;
    logic [GATE_W-1:0] gate_sel;
    logic              idx_ok;
    logic              tmr_load, tmr_exp;
    logic [CNT_W-1:0]  tmr_val;

    logic [NCORES-1:0] por_q, por2_q, core_q, dbg_q, trc_q, simd_q, l1_q;
    logic [GATE_W-1:0] gate_q;
    logic              done_q, err_q;

    assign idx_ok = (core_idx_i < IDX_W'(NCORES));

    cpwr_sel_decode #(
        .NCORES (NCORES),
        .IDX_W  (IDX_W),
        .GATE_W (GATE_W)
    ) i_sel (
        .idx_i      (idx_q),
        .variant_i  (var_q),
        .core_sel_o (core_sel),
        .gate_sel_o (gate_sel)
    );

    // The wait timer is loaded in the cycle that enters a wait state.
    assign tmr_load = ((state_q == ST_POR_SET) && var_q) ||
                      (state_q == ST_GATE_CLR) ||
                      ((state_q == ST_POR_REL) && var_q);
    assign tmr_val  = (state_q == ST_GATE_CLR) ? CNT_W'(LONG_WAIT_CYC - 1)
                                               : CNT_W'(SHORT_WAIT_CYC - 1);

    cpwr_wait_timer #(
        .CNT_W (CNT_W)
    ) i_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (start_i && idx_ok) state_d = ST_POR_SET;
            ST_POR_SET:     state_d = var_q ? ST_POR2_HOLD : ST_L1_CLR;
            ST_POR2_HOLD:   if (tmr_exp) state_d = ST_L1_CLR;
            ST_L1_CLR:      state_d = ST_DBG_SET;
            ST_DBG_SET:     state_d = ST_SW_WAIT;
            ST_SW_WAIT:     if (sw_ack_i) state_d = ST_GATE_CLR;
            ST_GATE_CLR:    state_d = ST_GATE_SETTLE;
            ST_GATE_SETTLE: if (tmr_exp) state_d = ST_POR_REL;
            ST_POR_REL:     state_d = var_q ? ST_POR2_SETTLE : ST_FINISH;
            ST_POR2_SETTLE: if (tmr_exp) state_d = ST_FINISH;
            ST_FINISH:      state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // Registered outputs: each state's action appears one edge after it is entered.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            big_q  <= 1'b0;
            var_q  <= 1'b0;
            por_q  <= '1;
            por2_q <= '1;
            core_q <= '0;
            dbg_q  <= '1;
            trc_q  <= '1;
            simd_q <= '0;
            l1_q   <= '1;
            gate_q <= '1;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (idx_ok) begin
                            idx_q <= core_idx_i;
                            big_q <= big_core_i;
                            var_q <= variant_i;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_POR_SET: begin
                    por_q <= por_q & ~core_sel;
                    if (var_q) por2_q <= por2_q & ~core_sel;
                end
                ST_L1_CLR: begin
                    if (!big_q) l1_q <= l1_q & ~core_sel;
                end
                ST_DBG_SET: begin
                    dbg_q <= dbg_q & ~core_sel;
                    if (!big_q) trc_q <= trc_q & ~core_sel;
                end
                ST_GATE_CLR: begin
                    gate_q <= gate_q & ~gate_sel;
                end
                ST_POR_REL: begin
                    por_q <= por_q | core_sel;
                    if (var_q) por2_q <= por2_q | core_sel;
                end
                ST_FINISH: begin
                    dbg_q  <= dbg_q  | core_sel;
                    core_q <= core_q | core_sel;
                    if (big_q) simd_q <= simd_q | core_sel;
                    else       trc_q  <= trc_q  | core_sel;
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign sw_req_o     = (state_q == ST_SW_WAIT);
    assign busy_o       = (state_q != ST_IDLE);
    assign done_o       = done_q;
    assign err_o        = err_q;
    assign por_n_o      = por_q;
    assign por2_n_o     = por2_q;
    assign core_rst_n_o = core_q;
    assign dbg_rst_n_o  = dbg_q;
    assign trc_rst_n_o  = trc_q;
    assign simd_rst_n_o = simd_q;
    assign l1_rst_dis_o = l1_q;
    assign pwr_gate_o   = gate_q;

    AST_ONE_CORE_IN_POR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~por_n_o)); // R1

    AST_L1_UNDER_POR: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_rst_dis_o != $past(l1_rst_dis_o)) |-> (por_n_o != '1)); // R2

    AST_REQ_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_req_o) |-> $past(sw_ack_i)); // R4

    AST_GATE_UNDER_POR: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_gate_o != $past(pwr_gate_o)) |-> (por_n_o != '1)); // R4

    AST_DONE_ALL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (por_n_o == '1 && dbg_rst_n_o == '1 && !busy_o)); // R8

    AST_BAD_IDX_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !idx_ok) |=> (err_o && !busy_o)); // R9

endmodule

// File: tb/test_core_pwrup_seq.sv
module test_core_pwrup_seq;

    localparam int NL = 12;
    localparam int NS = 5;

    typedef struct packed {
        logic [3:0] por;
        logic [3:0] por2;
        logic [3:0] core;
        logic [3:0] dbg;
        logic [3:0] trc;
        logic [3:0] simd;
        logic [3:0] l1;
        logic [4:0] gate;
        logic       sw_req;
        logic       busy;
        logic       done;
        logic       err;
    } snap_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] idx = '0;
    logic       big = 1'b0;
    logic       vmode = 1'b0;
    logic       ack_r = 1'b0;
    logic       spur_r = 1'b0;
    logic       sw_ack;

    logic       sw_req, busy, done, err;
    logic [3:0] por_n, por2_n, core_n, dbg_n, trc_n, simd_n, l1d;
    logic [4:0] gate;

    assign sw_ack = ack_r | spur_r;

    core_pwrup_seq #(
        .NCORES         (4),
        .LONG_WAIT_CYC  (NL),
        .SHORT_WAIT_CYC (NS)
    ) i_core_pwrup_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .core_idx_i   (idx),
        .big_core_i   (big),
        .variant_i    (vmode),
        .sw_ack_i     (sw_ack),
        .sw_req_o     (sw_req),
        .busy_o       (busy),
        .done_o       (done),
        .err_o        (err),
        .por_n_o      (por_n),
        .por2_n_o     (por2_n),
        .core_rst_n_o (core_n),
        .dbg_rst_n_o  (dbg_n),
        .trc_rst_n_o  (trc_n),
        .simd_rst_n_o (simd_n),
        .l1_rst_dis_o (l1d),
        .pwr_gate_o   (gate)
    );

    always #2 clk = ~clk;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    finished = 0;
    bit    mon_en = 0;
    int    ack_delay = 0;
    snap_t m;
    snap_t exp_q[$];
    int    gap_q[$];
    string tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic snap_t snap();
        snap_t s;
        s.por = por_n;   s.por2 = por2_n; s.core = core_n; s.dbg = dbg_n;
        s.trc = trc_n;   s.simd = simd_n; s.l1 = l1d;      s.gate = gate;
        s.sw_req = sw_req; s.busy = busy; s.done = done;   s.err = err;
        return s;
    endfunction

    function automatic void push(int gap, string tag);
        exp_q.push_back(m);
        gap_q.push_back(gap);
        tag_q.push_back(tag);
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Power switch sequencer model
    initial begin
        int  cnt = 0;
        bit  given = 0;
        forever begin
            @(negedge clk);
            if (sw_req && !given) begin
                if (cnt >= ack_delay) begin
                    ack_r = 1'b1;
                    given = 1;
                end else begin
                    cnt++;
                end
            end else begin
                ack_r = 1'b0;
            end
            if (!sw_req) begin
                given = 0;
                cnt = 0;
            end
        end
    end

    // Monitor: pops one expected snapshot per observed output change
    initial begin
        snap_t last, cur, e;
        int    last_cyc, g;
        string t;
        wait (mon_en);
        last = snap();
        last_cyc = cyc;
        forever begin
            @(negedge clk);
            cur = snap();
            if (cur !== last) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R10 unexpected change: got %h expected %h", cur, last);
                end else begin
                    e = exp_q.pop_front();
                    g = gap_q.pop_front();
                    t = tag_q.pop_front();
                    if (cur !== e) begin
                        fails++;
                        $display("FAIL %s snapshot: got %h expected %h", t, cur, e);
                    end
                    if (g >= 0) begin
                        checks++;
                        if (cyc - last_cyc != g) begin
                            fails++;
                            $display("FAIL %s gap: got %0d expected %0d", t, cyc - last_cyc, g);
                        end
                    end
                end
                last = cur;
                last_cyc = cyc;
            end
        end
    end

    task automatic pulse_start(int ci, bit b, bit v);
        @(negedge clk);
        start = 1'b1;
        idx = 3'(ci);
        big = b;
        vmode = v;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        do @(negedge clk); while (busy || exp_q.size() != 0);
        repeat (3) @(negedge clk);
    endtask

    // Driver: pushes the expected steps, then launches the request
    task automatic run_seq(int ci, bit b, bit v, int dly, bit poke);
        int gi;
        ack_delay = dly;
        m.busy = 1'b1;
        push(-1, "R1");
        m.por[ci] = 1'b0;
        if (v) m.por2[ci] = 1'b0;
        push(1, v ? "R7" : "R1");
        if (!b) begin
            m.l1[ci] = 1'b0;
            push(v ? NS + 1 : 1, v ? "R7" : "R2");
        end
        m.dbg[ci] = 1'b0;
        if (!b) m.trc[ci] = 1'b0;
        m.sw_req = 1'b1;
        push(b ? (v ? NS + 2 : 2) : 1, "R3");
        m.sw_req = 1'b0;
        push(-1, "R4");
        gi = (v && ci == 0) ? 4 : ci;
        m.gate[gi] = 1'b0;
        push(1, "R5");
        m.por[ci] = 1'b1;
        if (v) m.por2[ci] = 1'b1;
        push(NL + 1, "R6");
        m.dbg[ci] = 1'b1;
        m.core[ci] = 1'b1;
        if (b) m.simd[ci] = 1'b1;
        else   m.trc[ci] = 1'b1;
        m.done = 1'b1;
        m.busy = 1'b0;
        push(v ? NS + 1 : 1, v ? "R7" : "R8");
        m.done = 1'b0;
        push(1, "R8");
        pulse_start(ci, b, v);
        if (poke) begin
            do @(negedge clk); while (!sw_req);
            pulse_start(1, 1'b0, 1'b0);   // R10: start while busy
        end
        drain();
    endtask

    initial begin
        snap_t r;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        m = '0;
        m.por = '1; m.por2 = '1; m.dbg = '1; m.trc = '1; m.l1 = '1; m.gate = '1;
        r = snap();
        checks++;
        if (r !== m) begin
            fails++;
            $display("FAIL R11 reset: got %h expected %h", r, m);
        end
        mon_en = 1;
        @(negedge clk);

        run_seq(2, 1'b0, 1'b0, 3, 1'b0);   // little core, base wiring
        run_seq(1, 1'b1, 1'b0, 0, 1'b0);   // big core, immediate ack
        run_seq(0, 1'b0, 1'b1, 2, 1'b1);   // little, variant, core 0 on bit 4, busy poke

        // R9: out-of-range index
        m.err = 1'b1; push(-1, "R9");
        m.err = 1'b0; push(1, "R9");
        pulse_start(5, 1'b0, 1'b0);
        drain();

        // R10: acknowledge with no pending request
        @(negedge clk);
        spur_r = 1'b1;
        repeat (2) @(negedge clk);
        spur_r = 1'b0;
        repeat (4) @(negedge clk);
        r = snap();
        checks++;
        if (r !== m) begin
            fails++;
            $display("FAIL R10 stray ack: got %h expected %h", r, m);
        end

        run_seq(3, 1'b1, 1'b1, 1, 1'b0);   // big core, variant
        run_seq(0, 1'b1, 1'b0, 4, 1'b0);   // core 0 base wiring uses bit 0 (R5)

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R8 pending steps: got %0d expected 0", exp_q.size());
        end
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R8 watchdog: got timeout expected completion");
            summary();
        end
    end

endmodule